// File: doc/BRIEF.md
# Audio Processor Power-Up and Reset Sequencer

This block brings an audio signal processor from standby into normal operation. It watches four inputs that are synchronous to the reference clock: an active-low standby input, an active-low reset request, a flag saying the reference voltages have reached their working level, and a flag saying the oscillator and PLL have settled. While standby is low it turns off the oscillator enable and the processor clock enable, and it clears its own state.

A reset request counts only while the reference and the clock are both good, and only once it has stayed low for a minimum number of reference clock cycles. A shorter pulse leaves the sequencer waiting. An accepted reset, seen when the request returns high, starts a fixed converter calibration window. During that window the audio path is muted. After the window the sequencer raises the audio enable and the host-ready flag, which allows serial access.

Both durations are parameters counted in reference clock cycles. At the default 16.9344 MHz clock, which is 384 times 44.1 kHz, the defaults give 0.5 s for the minimum reset and 100 ms for the calibration.

Top module: `audio_pwr_sequencer`

## Requirements
- R1: While `stby_n` is 0, `osc_en`, `core_clk_en`, `cal_mute`, `audio_en` and `host_ready` are all 0.
- R2: `osc_en` equals `stby_n`, and `core_clk_en` is 1 exactly when `stby_n` and `clk_stable` are both 1.
- R3: Reset low time is counted only on rising edges where `vref_ok` and `clk_stable` are both 1. An edge where either is 0 discards the count gathered so far.
- R4: A reset is accepted when `rst_req_n` was sampled 0, with R3 satisfied, on at least `MIN_RST_CYC` consecutive rising edges and is then sampled 1. `cal_mute` goes to 1 from the next cycle on.
- R5: A reset pulse shorter than `MIN_RST_CYC` is ignored. `cal_mute`, `audio_en` and `host_ready` stay 0.
- R6: `cal_mute` stays 1 for exactly `CAL_CYC` clock cycles. `audio_en` is 0 during that time.
- R7: When calibration ends, `audio_en` and `host_ready` both go to 1 in the same cycle. They stay 1 until a reset request, a loss of reference or clock, or standby. `cal_mute` and `audio_en` are never 1 together.
- R8: After `stby_n` returns to 1, the sequencer waits for a new valid reset, even if an earlier reset had completed.
- R9: A reset request during calibration or operation clears `cal_mute`, `audio_en` and `host_ready` on the next cycle. That request is then qualified under R4 and R5.
- R10: If `vref_ok` or `clk_stable` is 0 at a rising edge during calibration or operation, the sequencer returns to waiting on the next cycle and needs a new valid reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| stby_n | input | 1 | Standby, active low; also clears the sequencer asynchronously |
| rst_req_n | input | 1 | Reset request, active low |
| vref_ok | input | 1 | Reference voltages above working level |
| clk_stable | input | 1 | Oscillator and PLL settled |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Processor clock enable |
| cal_mute | output | 1 | Converter calibration running, audio muted |
| audio_en | output | 1 | Audio input and output enabled |
| host_ready | output | 1 | Serial host access allowed |

## Verification
The hardest cases to reach are the ones where the reset length sits right at the acceptance threshold. The worst of these is a reset that would be long enough in total but is split by a short loss of the reference, so that neither piece reaches the minimum. The bench shrinks both durations and sweeps the pulse length across the threshold, one cycle at a time. It drops `vref_ok` for a single cycle in the middle of a low reset. It also sends a second reset, first short and then long, while the block is already running.

// File: rtl/audio_pwr_sequencer.sv
module audio_pwr_sequencer #(
  parameter int unsigned MIN_RST_CYC = 8467200,
  parameter int unsigned CAL_CYC     = 1693440
) (
  input  logic clk,
  input  logic stby_n,
  input  logic rst_req_n,
  input  logic vref_ok,
  input  logic clk_stable,
  output logic osc_en,
  output logic core_clk_en,
  output logic cal_mute,
  output logic audio_en,
  output logic host_ready
);

  localparam int unsigned TOP = (MIN_RST_CYC > CAL_CYC) ? MIN_RST_CYC : CAL_CYC;
  localparam int CW = $clog2(TOP + 1);
  localparam logic [CW-1:0] MIN_V    = CW'(MIN_RST_CYC);
  localparam logic [CW-1:0] CAL_LAST = CW'(CAL_CYC - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_CAL, S_RUN} st_t;

  st_t            st, st_nx;
  logic [CW-1:0]  cnt, cnt_nx;
  logic           supplies_ok;

  assign supplies_ok = vref_ok & clk_stable;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      S_IDLE: begin
        if (!rst_req_n && supplies_ok) begin
          st_nx  = S_HOLD;
          cnt_nx = ONE;
        end
      end
      S_HOLD: begin
        if (!supplies_ok) begin
          st_nx  = S_IDLE;
          cnt_nx = '0;
        end else if (rst_req_n) begin
          st_nx  = (cnt >= MIN_V) ? S_CAL : S_IDLE;
          cnt_nx = '0;
        end else if (cnt < MIN_V) begin
          cnt_nx = cnt + ONE;
        end
      end
      S_CAL, S_RUN: begin
        if (!supplies_ok) begin
          st_nx  = S_IDLE;
          cnt_nx = '0;
        end else if (!rst_req_n) begin
          st_nx  = S_HOLD;
          cnt_nx = ONE;
        end else if (st == S_CAL) begin
          if (cnt == CAL_LAST) begin
            st_nx  = S_RUN;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt + ONE;
          end
        end
      end
      default: begin
        st_nx  = S_IDLE;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge stby_n) begin
    if (!stby_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign osc_en      = stby_n;
  assign core_clk_en = stby_n & clk_stable;
  assign cal_mute    = (st == S_CAL);
  assign audio_en    = (st == S_RUN);
  assign host_ready  = (st == S_RUN);

  logic [CW-1:0] mute_len;
  always_ff @(posedge clk or negedge stby_n) begin
    if (!stby_n)       mute_len <= '0;
    else if (cal_mute) mute_len <= mute_len + ONE;
    else               mute_len <= '0;
  end

  AST_STBY_STOP: assert property (@(posedge clk) !stby_n |-> !(osc_en || core_clk_en || cal_mute || audio_en || host_ready)); // R1
  AST_ACCEPT_ON_RELEASE: assert property (@(posedge clk) disable iff (!stby_n) $rose(cal_mute) |-> ($past(rst_req_n) && !$past(rst_req_n, 2))); // R4
  AST_CAL_WINDOW: assert property (@(posedge clk) disable iff (!stby_n) ($fell(cal_mute) && audio_en) |-> (mute_len == CW'(CAL_CYC))); // R6
  AST_MUTE_EXCL: assert property (@(posedge clk) disable iff (!stby_n) !(cal_mute && audio_en)); // R7
  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!stby_n) !(vref_ok && clk_stable) |=> !(audio_en || cal_mute)); // R10
  AST_RESET_DROPS: assert property (@(posedge clk) disable iff (!stby_n) !rst_req_n |=> !(audio_en || host_ready)); // R9

endmodule

// File: tb/test_audio_pwr_sequencer.sv
module test_audio_pwr_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_R = 5;
  localparam int CAL_N = 7;

  logic clk = 1'b0;
  logic stby_n, rst_req_n, vref_ok, clk_stable;
  logic osc_en, core_clk_en, cal_mute, audio_en, host_ready;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_pwr_sequencer #(.MIN_RST_CYC(MIN_R), .CAL_CYC(CAL_N)) i_audio_pwr_sequencer (
    .clk(clk), .stby_n(stby_n), .rst_req_n(rst_req_n), .vref_ok(vref_ok),
    .clk_stable(clk_stable), .osc_en(osc_en), .core_clk_en(core_clk_en),
    .cal_mute(cal_mute), .audio_en(audio_en), .host_ready(host_ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk) rst_req_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_req_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure_cal();
    int len = 0;
    while (cal_mute && len < 50) begin
      chk(audio_en == 1'b0, "R6 audio_en during cal", int'(audio_en), 0);
      len++;
      @(negedge clk);
    end
    chk(len == CAL_N, "R6 cal length", len, CAL_N);
    chk(audio_en && host_ready, "R7 enabled after cal", int'({audio_en, host_ready}), 3);
  endtask

  task automatic standby_cycle();
    @(negedge clk) stby_n = 1'b0;
    #1;
    chk({osc_en, core_clk_en, cal_mute, audio_en, host_ready} == 5'b0, "R1 standby outputs",
        int'({osc_en, core_clk_en, cal_mute, audio_en, host_ready}), 0);
    @(negedge clk) stby_n = 1'b1;
    #1;
    chk(osc_en && core_clk_en, "R2 enables after standby", int'({osc_en, core_clk_en}), 3);
    repeat (3) @(negedge clk);
    chk(!audio_en && !cal_mute, "R8 waits after standby", int'({audio_en, cal_mute}), 0);
  endtask

  initial begin
    stby_n = 1'b1; rst_req_n = 1'b1; vref_ok = 1'b1; clk_stable = 1'b1;
    #1 stby_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({osc_en, core_clk_en, cal_mute, audio_en, host_ready} == 5'b0, "R1 reset state",
        int'({osc_en, core_clk_en, cal_mute, audio_en, host_ready}), 0);
    stby_n = 1'b1;
    @(negedge clk);
    chk(osc_en && core_clk_en && !audio_en, "R2 idle enables", int'({osc_en, core_clk_en, audio_en}), 6);

    for (int n = 1; n <= MIN_R + 4; n++) begin
      pulse(n);
      if (n >= MIN_R) begin
        chk(cal_mute == 1'b1, "R4 accept long reset", int'(cal_mute), 1);
        measure_cal();
        repeat (3) @(negedge clk);
        chk(audio_en && host_ready, "R7 stays enabled", int'({audio_en, host_ready}), 3);
        standby_cycle();
        pulse(MIN_R - 1);
        chk(!cal_mute && !audio_en, "R8 short after standby", int'({cal_mute, audio_en}), 0);
      end else begin
        chk(cal_mute == 1'b0, "R5 short reset ignored", int'(cal_mute), 0);
        repeat (2) @(negedge clk);
        chk(!audio_en && !host_ready && !cal_mute, "R5 stays waiting",
            int'({audio_en, host_ready, cal_mute}), 0);
      end
    end

    @(negedge clk) clk_stable = 1'b0;
    #1 chk(!core_clk_en && osc_en, "R2 core clock gated", int'({core_clk_en, osc_en}), 1);
    @(negedge clk) clk_stable = 1'b1;

    @(negedge clk) vref_ok = 1'b0; rst_req_n = 1'b0;
    repeat (MIN_R + 3) @(negedge clk);
    vref_ok = 1'b1; rst_req_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cal_mute, "R3 no count without vref", int'(cal_mute), 0);

    @(negedge clk) rst_req_n = 1'b0;
    repeat (3) @(negedge clk);
    vref_ok = 1'b0;
    @(negedge clk) vref_ok = 1'b1;
    repeat (MIN_R - 1) @(negedge clk);
    rst_req_n = 1'b1;
    @(negedge clk);
    chk(!cal_mute, "R3 split reset rejected", int'(cal_mute), 0);

    @(negedge clk) rst_req_n = 1'b0;
    repeat (2) @(negedge clk);
    clk_stable = 1'b0;
    @(negedge clk) clk_stable = 1'b1;
    repeat (MIN_R) @(negedge clk);
    rst_req_n = 1'b1;
    @(negedge clk);
    chk(cal_mute, "R3 restarted count accepted", int'(cal_mute), 1);
    measure_cal();

    @(negedge clk) rst_req_n = 1'b0;
    @(negedge clk);
    chk(!audio_en && !host_ready, "R9 reset drops audio", int'({audio_en, host_ready}), 0);
    @(negedge clk) rst_req_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!audio_en && !cal_mute, "R9 short reset from run", int'({audio_en, cal_mute}), 0);

    pulse(MIN_R);
    measure_cal();
    pulse(MIN_R + 1);
    chk(cal_mute, "R9 long reset from run", int'(cal_mute), 1);
    @(negedge clk) rst_req_n = 1'b0;
    @(negedge clk);
    chk(!cal_mute, "R9 reset during cal", int'(cal_mute), 0);
    repeat (MIN_R) @(negedge clk);
    rst_req_n = 1'b1;
    @(negedge clk);
    measure_cal();

    @(negedge clk) vref_ok = 1'b0;
    @(negedge clk);
    chk(!audio_en && !host_ready, "R10 vref loss in run", int'({audio_en, host_ready}), 0);
    vref_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(!audio_en, "R10 stays waiting", int'(audio_en), 0);

    pulse(MIN_R);
    repeat (2) @(negedge clk);
    clk_stable = 1'b0;
    @(negedge clk) clk_stable = 1'b1;
    chk(!cal_mute && !audio_en, "R10 clock loss in cal", int'({cal_mute, audio_en}), 0);
    repeat (CAL_N + 2) @(negedge clk);
    chk(!audio_en, "R10 no resume after loss", int'(audio_en), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule